// File: doc/BRIEF.md
# SPI Flash Command Front End

This block sits on the device side of a serial NOR flash and turns SPI traffic into array operations. It shifts in an opcode byte, a 24-bit address and any dummy or data bytes. It shifts out array bytes, the status byte or a fixed signature byte. It also owns the status byte: the busy flag, the write-enable latch, three protection-level bits and two failure flags.

Program and erase requests are checked against the latch, the busy flag and the protected region. A request that passes all of these checks becomes strobes on a simple array port. The storage itself lives outside the block. It returns read data for the presented address, accepts write and erase strobes, and reports busy and failure.

The inputs `sck`, `cs_n` and `si` are sampled with the block clock. Each SCK level must last at least two clock cycles.

Top module: `spi_flash_cmd_ctrl`

## Requirements
- R1: SPI modes 0 and 3 both work. SI is captured on each rising SCK edge, and SO changes only on falling SCK edges. Every field travels most significant bit first.
- R2: READ (0x03) sends the three address bytes and then streams data bytes starting at that address, with no gap. FAST_READ (0x0B) does the same after one extra dummy byte. The address increments after each byte and wraps from 0xFFFFFF to 0x000000.
- R3: Raising `cs_n` during data output, even in the middle of a byte, stops the output. `so_en` drops and the next transaction is decoded normally.
- R4: WREN (0x06) sets the write-enable latch and WRDI (0x04) clears it. RES (0xAB) returns the signature byte repeatedly after three dummy bytes and leaves the latch unchanged.
- R5: RDSR (0x05) repeats the status byte. The bit positions are: bit0 busy, bit1 write-enable latch, bits 4:2 protection level, bit5 erase failure, bit6 program failure, bit7 zero.
- R6: WRR, PP, SE and BE are accepted only when all three conditions hold: the latch is 1, `cs_n` rises on a byte boundary, and the byte count is exact. The exact count is 2 bytes for WRR, 4 for SE, 1 for BE, and at least 5 for PP. A request that fails any condition changes nothing, including the latch.
- R7: WRR (0x01) plus one data byte copies data bits 4:2 into the protection level and clears the latch at once. The busy flag is never set by WRR.
- R8: A protection level n other than 0 protects the addresses whose top 7-n bits are all ones. Level 7 protects everything. PP or SE to a protected address is dropped. BE (0xC7) is dropped unless the level is 0.
- R9: PP (0x02) buffers its data bytes at consecutive offsets within the addressed 256-byte page, wrapping from offset 255 to 0. A later byte overwrites an earlier one at the same offset. After acceptance, each buffered offset produces exactly one `arr_wr` strobe.
- R10: SE (0xD8) produces one `arr_erase` strobe with the given address and `arr_bulk` low. BE produces one strobe with `arr_bulk` high.
- R11: The busy flag is 1 from acceptance until the array, having raised `arr_busy` the cycle after the last strobe, drops it. The latch is cleared when the operation ends.
- R12: While busy, RDSR still works. READ, FAST_READ and RES never enable SO. WREN, WRDI, WRR, PP, SE, BE and CLSR have no effect.
- R13: If `arr_err` is high when a program ends, the program failure bit is set; if high when an erase ends, the erase failure bit is set. CLSR (0x30) clears both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_en | output | 1 | SO drive enable |
| arr_addr | output | ADDR_W | Array address for reads, writes and erases |
| arr_rdata | input | 8 | Array read data for `arr_addr` |
| arr_wr | output | 1 | Write strobe for one byte |
| arr_wdata | output | 8 | Byte to write |
| arr_erase | output | 1 | Erase strobe |
| arr_bulk | output | 1 | Erase covers the whole array |
| arr_busy | input | 1 | Array operation in progress |
| arr_err | input | 1 | Array operation failed, sampled at completion |

## Verification
The assertions assume four things about the inputs. SCK and chip-select changes are synchronous to `clk`. Each SCK level is held for several clocks. `arr_busy` rises in the cycle after a strobe. `arr_err` is stable while an operation finishes.

The bench drives every pin on the falling clock edge and holds each SCK level for four clocks. Its array model loads a busy counter on every strobe, so busy appears exactly one cycle later. The failure input changes only while the block is idle.

// File: rtl/spi_flash_cmd_ctrl.sv
module spi_flash_cmd_ctrl #(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8,
  parameter int CNT_W = 10,
  parameter logic [7:0] SIG = 8'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_en,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [7:0]        arr_rdata,
  output logic              arr_wr,
  output logic [7:0]        arr_wdata,
  output logic              arr_erase,
  output logic              arr_bulk,
  input  logic              arr_busy,
  input  logic              arr_err
);
  localparam int PAGE = 1 << PAGE_W;
  localparam logic [7:0] OP_WRR = 8'h01, OP_PP = 8'h02, OP_READ = 8'h03, OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05, OP_WREN = 8'h06, OP_FAST = 8'h0B, OP_CLSR = 8'h30;
  localparam logic [7:0] OP_RES = 8'hAB, OP_BE = 8'hC7, OP_SE = 8'hD8;

  typedef enum logic [2:0] {S_IDLE, S_STREAM, S_ERASE, S_SETTLE, S_WAIT} st_t;

  function automatic logic prot(input logic [2:0] lvl, input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = ~({ADDR_W{1'b1}} >> (3'd7 - lvl));
    return (lvl != 3'd0) && ((a & m) == m);
  endfunction

  logic sck_q, cs_q;
  logic [2:0] bitc;
  logic [CNT_W-1:0] bytec, hdr;
  logic [6:0] sh;
  logic [7:0] cmd, osh, rx_byte, out_val, status;
  logic [ADDR_W-1:0] addr, rd_ptr, op_addr;
  logic [PAGE_W-1:0] off, sidx;
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pval;
  logic wel, perr, eerr, out_on, so_q, op_prog, op_bulk, allow;
  logic [2:0] bp;
  st_t st;

  logic rise, fall, cs_rise, wip, byte_done, out_go, aligned;
  logic do_wren, do_wrdi, do_clsr, do_wrr, do_pp, do_se, do_be;

  assign rise      = sck & ~sck_q & ~cs_n;
  assign fall      = ~sck & sck_q & ~cs_n;
  assign cs_rise   = cs_n & ~cs_q;
  assign wip       = st != S_IDLE;
  assign byte_done = rise && bitc == 3'd7;
  assign rx_byte   = {sh, si};
  assign status    = {1'b0, perr, eerr, bp, wel, wip};

  always_comb begin
    hdr = '0;
    allow = 1'b0;
    case (cmd)
      OP_READ: begin hdr = CNT_W'(4); allow = !wip; end
      OP_FAST: begin hdr = CNT_W'(5); allow = !wip; end
      OP_RES:  begin hdr = CNT_W'(4); allow = !wip; end
      OP_RDSR: begin hdr = CNT_W'(1); allow = 1'b1; end
      default: ;
    endcase
  end

  assign out_go  = allow && bytec != '0 && bytec >= hdr;
  assign out_val = (cmd == OP_RDSR) ? status : (cmd == OP_RES) ? SIG : arr_rdata;

  assign aligned = cs_rise && bitc == 3'd0 && !wip;
  assign do_wren = aligned && bytec == CNT_W'(1) && cmd == OP_WREN;
  assign do_wrdi = aligned && bytec == CNT_W'(1) && cmd == OP_WRDI;
  assign do_clsr = aligned && bytec == CNT_W'(1) && cmd == OP_CLSR;
  assign do_wrr  = aligned && bytec == CNT_W'(2) && cmd == OP_WRR && wel;
  assign do_pp   = aligned && bytec >= CNT_W'(5) && cmd == OP_PP && wel && !prot(bp, addr);
  assign do_se   = aligned && bytec == CNT_W'(4) && cmd == OP_SE && wel && !prot(bp, addr);
  assign do_be   = aligned && bytec == CNT_W'(1) && cmd == OP_BE && wel && bp == 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; bitc <= '0; bytec <= '0; sh <= '0;
      cmd <= '0; addr <= '0; rd_ptr <= '0; off <= '0; pval <= '0;
      osh <= '0; so_q <= 1'b0; out_on <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_q) begin
        bitc <= '0; bytec <= '0; out_on <= 1'b0;
        if (!wip) pval <= '0;
      end else begin
        if (rise) begin
          sh   <= {sh[5:0], si};
          bitc <= bitc + 3'd1;
          if (byte_done) begin
            if (bytec != '1) bytec <= bytec + CNT_W'(1);
            if (bytec == '0) cmd <= rx_byte;
            if (bytec >= CNT_W'(1) && bytec <= CNT_W'(3)) addr <= {addr[ADDR_W-9:0], rx_byte};
            if (bytec == CNT_W'(3)) begin
              rd_ptr <= {addr[ADDR_W-9:0], rx_byte};
              off    <= rx_byte[PAGE_W-1:0];
            end
            if (bytec >= CNT_W'(4) && cmd == OP_PP && !wip) begin
              pval[off] <= 1'b1;
              off       <= off + 1'b1;
            end
          end
        end
        if (fall && out_go) begin
          out_on <= 1'b1;
          if (bitc == 3'd0) begin
            so_q <= out_val[7];
            osh  <= {out_val[6:0], 1'b0};
            if (cmd == OP_READ || cmd == OP_FAST) rd_ptr <= rd_ptr + 1'b1;
          end else begin
            so_q <= osh[7];
            osh  <= {osh[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (byte_done && bytec >= CNT_W'(4) && cmd == OP_PP && !wip) pbuf[off] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wel <= 1'b0; bp <= '0; perr <= 1'b0; eerr <= 1'b0;
      sidx <= '0; op_addr <= '0; op_prog <= 1'b0; op_bulk <= 1'b0;
    end else begin
      if (do_wren) wel <= 1'b1;
      if (do_wrdi) wel <= 1'b0;
      if (do_clsr) begin perr <= 1'b0; eerr <= 1'b0; end
      if (do_wrr) begin bp <= addr[4:2]; wel <= 1'b0; end
      case (st)
        S_IDLE: begin
          if (do_pp) begin
            st <= S_STREAM; sidx <= '0; op_prog <= 1'b1; op_bulk <= 1'b0; op_addr <= addr;
          end else if (do_se || do_be) begin
            st <= S_ERASE; op_prog <= 1'b0; op_bulk <= do_be; op_addr <= do_be ? '0 : addr;
          end
        end
        S_STREAM: begin
          sidx <= sidx + 1'b1;
          if (sidx == PAGE_W'(PAGE - 1)) st <= S_SETTLE;
        end
        S_ERASE:  st <= S_SETTLE;
        S_SETTLE: st <= S_WAIT;
        S_WAIT: if (!arr_busy) begin
          st  <= S_IDLE;
          wel <= 1'b0;
          if (arr_err) begin
            if (op_prog) perr <= 1'b1;
            else eerr <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign so        = so_q;
  assign so_en     = out_on && !cs_n;
  assign arr_wr    = st == S_STREAM && pval[sidx];
  assign arr_wdata = pbuf[sidx];
  assign arr_erase = st == S_ERASE;
  assign arr_bulk  = st == S_ERASE && op_bulk;
  assign arr_addr  = (st == S_STREAM) ? {op_addr[ADDR_W-1:PAGE_W], sidx} :
                     (st == S_ERASE) ? op_addr : rd_ptr;

  assert_accept_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));
  assert_accept_on_cs_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_n));
  assert_bulk_unprotected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_bulk |-> bp == 3'd0);
  assert_write_unprotected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> !prot(bp, arr_addr));
  assert_end_clears_wel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  assert_busy_no_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (so_en && wip) |-> cmd == OP_RDSR);
endmodule

// File: tb/test_spi_flash_cmd_ctrl.sv
module test_spi_flash_cmd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_en, arr_wr, arr_erase, arr_bulk, arr_busy;
  logic arr_err = 1'b0;
  logic [23:0] arr_addr;
  logic [7:0] arr_rdata = 8'h00, arr_wdata;

  int total = 0, bad = 0;
  int wr_cnt = 0, er_cnt = 0, busy_len = 6, bcnt = 0;
  logic [23:0] er_addr = '0;
  logic er_bulk = 1'b0, mode3 = 1'b0, so_seen = 1'b0;
  logic [7:0] mem [logic [23:0]];
  logic [7:0] rbuf [4];

  always #2.5 clk = ~clk;

  spi_flash_cmd_ctrl i_spi_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_en(so_en),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_wr(arr_wr), .arr_wdata(arr_wdata),
    .arr_erase(arr_erase), .arr_bulk(arr_bulk), .arr_busy(arr_busy), .arr_err(arr_err));

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] dat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  assign arr_busy = bcnt != 0;
  always @(posedge clk) begin
    arr_rdata <= mem.exists(arr_addr) ? mem[arr_addr] : pat(arr_addr);
    if (arr_wr) begin mem[arr_addr] = arr_wdata; wr_cnt++; end
    if (arr_erase) begin er_cnt++; er_addr = arr_addr; er_bulk = arr_bulk; end
    if (arr_wr || arr_erase) bcnt <= busy_len;
    else if (bcnt != 0) bcnt <= bcnt - 1;
  end
  always @(negedge clk) if (!cs_n && so_en) so_seen = 1'b1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic cs_lo(input logic m3);
    mode3 = m3; sck = m3; tick(2); so_seen = 1'b0; cs_n = 1'b0; tick(2);
  endtask
  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0; si = tx[i]; tick(4); rx[i] = so; sck = 1'b1; tick(4);
    end
  endtask
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx); xbits(tx, 8, rx); endtask
  task automatic send(input logic [7:0] b); logic [7:0] d; xfer(b, d); endtask
  task automatic cs_hi();
    if (!mode3) begin sck = 1'b0; tick(4); end
    cs_n = 1'b1; tick(4);
  endtask
  task automatic send_addr(input logic [23:0] a); send(a[23:16]); send(a[15:8]); send(a[7:0]); endtask
  task automatic cmd1(input logic [7:0] op); cs_lo(1'b0); send(op); cs_hi(); endtask
  task automatic cmda(input logic [7:0] op, input logic [23:0] a);
    cs_lo(1'b0); send(op); send_addr(a); cs_hi();
  endtask
  task automatic wrr(input logic [7:0] v); cs_lo(1'b0); send(8'h01); send(v); cs_hi(); endtask
  task automatic rdsr(input logic m3, output logic [7:0] s);
    cs_lo(m3); send(8'h05); xfer(8'h00, s); cs_hi();
  endtask
  task automatic read_n(input logic [7:0] op, input logic [23:0] a, input logic m3, input int n);
    cs_lo(m3); send(op); send_addr(a);
    if (op == 8'h0B) send(8'h00);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    cs_hi();
  endtask
  task automatic pp_n(input logic [23:0] a, input int n);
    cs_lo(1'b0); send(8'h02); send_addr(a);
    for (int i = 0; i < n; i++) send(dat(i));
    cs_hi();
  endtask
  task automatic wait_idle();
    logic [7:0] s;
    int k;
    for (k = 0; k < 200; k++) begin rdsr(1'b0, s); if (!s[0]) break; end
    chk("R11", "operation finishes", int'(k < 200), 1);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R5", "so_en after reset", so_en, 0);
    chk("R10", "no strobe after reset", arr_wr | arr_erase, 0);
    rdsr(1'b0, s);
    chk("R5", "status after reset", s, 8'h00);
  endtask

  task automatic t_wel();
    logic [7:0] s;
    cmd1(8'h06); rdsr(1'b1, s);
    chk("R4", "WREN sets latch", s, 8'h02);
    cs_lo(1'b0); send(8'h05); xfer(8'h00, s); chk("R5", "status first copy", s, 8'h02);
    xfer(8'h00, s); chk("R5", "status repeats", s, 8'h02); cs_hi();
    cmd1(8'h04); rdsr(1'b0, s);
    chk("R4", "WRDI clears latch", s, 8'h00);
  endtask

  task automatic t_read();
    read_n(8'h03, 24'h123456, 1'b0, 3);
    for (int i = 0; i < 3; i++) chk("R2", "READ mode 0 data", rbuf[i], pat(24'h123456 + 24'(i)));
    read_n(8'h0B, 24'hFFFFFF, 1'b1, 2);
    chk("R1", "FAST_READ mode 3 first byte", rbuf[0], pat(24'hFFFFFF));
    chk("R2", "address wraps to zero", rbuf[1], pat(24'h000000));
  endtask

  task automatic t_abort();
    logic [7:0] d, s;
    cs_lo(1'b0); send(8'h03); send_addr(24'h000100); xfer(8'h00, d);
    chk("R2", "read before abort", d, pat(24'h000100));
    xbits(8'h00, 3, d); cs_hi();
    chk("R3", "so_en was driven", so_seen, 1);
    chk("R3", "so_en off after CS rise", so_en, 0);
    rdsr(1'b0, s);
    chk("R3", "next command decoded", s, 8'h00);
  endtask

  task automatic t_pp();
    logic [7:0] s;
    int w0;
    w0 = wr_cnt;
    cmd1(8'h06); pp_n(24'h0010FE, 3); rdsr(1'b0, s);
    chk("R11", "busy and latch during program", s, 8'h03);
    wait_idle(); rdsr(1'b0, s);
    chk("R11", "latch cleared at end", s, 8'h00);
    chk("R9", "one strobe per byte", wr_cnt - w0, 3);
    read_n(8'h03, 24'h0010FE, 1'b0, 2);
    chk("R9", "byte at FE", rbuf[0], dat(0));
    chk("R9", "byte at FF", rbuf[1], dat(1));
    read_n(8'h03, 24'h001000, 1'b0, 1);
    chk("R9", "page wrap to offset 0", rbuf[0], dat(2));
  endtask

  task automatic t_gate();
    logic [7:0] s, d;
    int w0, e0;
    w0 = wr_cnt; e0 = er_cnt;
    pp_n(24'h004000, 1); rdsr(1'b0, s);
    chk("R6", "PP without latch dropped", wr_cnt - w0, 0);
    chk("R6", "status after dropped PP", s, 8'h00);
    cmd1(8'h06);
    cs_lo(1'b0); send(8'h02); send_addr(24'h004000); send(8'h11); xbits(8'h22, 3, d); cs_hi();
    rdsr(1'b0, s);
    chk("R6", "PP off byte boundary dropped", wr_cnt - w0, 0);
    chk("R6", "latch kept", s, 8'h02);
    cs_lo(1'b0); send(8'hD8); send(8'h01); send(8'h00); cs_hi();
    rdsr(1'b0, s);
    chk("R6", "short SE dropped", er_cnt - e0, 0);
    chk("R6", "latch kept after short SE", s, 8'h02);
    cmd1(8'h04);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    int w0, e0;
    w0 = wr_cnt; e0 = er_cnt;
    cmd1(8'h06); wrr(8'h1C); rdsr(1'b0, s);
    chk("R7", "WRR level 7, latch cleared", s, 8'h1C);
    cmd1(8'h06); cmd1(8'hC7); cmda(8'hD8, 24'h000000); rdsr(1'b0, s);
    chk("R8", "BE and SE dropped at level 7", er_cnt - e0, 0);
    chk("R8", "latch kept after drops", s, 8'h1E);
    wrr(8'h04); rdsr(1'b0, s);
    chk("R7", "WRR level 1", s, 8'h04);
    cmd1(8'h06); cmda(8'hD8, 24'hFC0000); pp_n(24'hFFFF00, 2);
    rdsr(1'b0, s);
    chk("R8", "SE in top region dropped", er_cnt - e0, 0);
    chk("R8", "PP in top region dropped", wr_cnt - w0, 0);
    chk("R8", "status after drops", s, 8'h06);
    cmda(8'hD8, 24'h010000); wait_idle(); rdsr(1'b0, s);
    chk("R10", "SE strobe count", er_cnt - e0, 1);
    chk("R10", "SE address", er_addr, 24'h010000);
    chk("R10", "SE not bulk", er_bulk, 0);
    chk("R11", "status after SE", s, 8'h04);
    cmd1(8'h06); wrr(8'h00); cmd1(8'h06); cmd1(8'hC7); wait_idle(); rdsr(1'b0, s);
    chk("R10", "BE strobe count", er_cnt - e0, 2);
    chk("R10", "BE bulk flag", er_bulk, 1);
    chk("R8", "status after BE", s, 8'h00);
  endtask

  task automatic t_res();
    logic [7:0] s;
    cmd1(8'h06);
    cs_lo(1'b1); send(8'hAB); send_addr(24'h000000); xfer(8'h00, rbuf[0]); xfer(8'h00, rbuf[1]); cs_hi();
    chk("R4", "signature", rbuf[0], 8'h17);
    chk("R4", "signature repeats", rbuf[1], 8'h17);
    rdsr(1'b0, s);
    chk("R4", "RES keeps latch", s, 8'h02);
    cmd1(8'h04);
  endtask

  task automatic t_err();
    logic [7:0] s;
    arr_err = 1'b1;
    cmd1(8'h06); pp_n(24'h003000, 1); wait_idle(); rdsr(1'b0, s);
    chk("R13", "program failure flag", s, 8'h40);
    cmd1(8'h06); cmda(8'hD8, 24'h020000); wait_idle(); rdsr(1'b0, s);
    chk("R13", "erase failure flag", s, 8'h60);
    arr_err = 1'b0;
  endtask

  task automatic t_busy();
    logic [7:0] s;
    busy_len = 1500;
    cmd1(8'h06); cmda(8'hD8, 24'h030000); rdsr(1'b0, s);
    chk("R12", "RDSR while busy", s, 8'h63);
    read_n(8'h03, 24'h000000, 1'b0, 2);
    chk("R12", "READ silent while busy", so_seen, 0);
    cmd1(8'h30); wrr(8'h1C); rdsr(1'b0, s);
    chk("R12", "CLSR and WRR ignored while busy", s, 8'h63);
    wait_idle(); rdsr(1'b0, s);
    chk("R12", "flags kept after busy", s, 8'h60);
    cmd1(8'h30); rdsr(1'b0, s);
    chk("R13", "CLSR clears flags", s, 8'h00);
    busy_len = 6;
  endtask

  task automatic t_page();
    int w0;
    w0 = wr_cnt;
    cmd1(8'h06); pp_n(24'h002000, 258); wait_idle();
    chk("R9", "at most one page written", wr_cnt - w0, 256);
    read_n(8'h03, 24'h002000, 1'b0, 3);
    chk("R9", "offset 0 overwritten", rbuf[0], dat(256));
    chk("R9", "offset 1 overwritten", rbuf[1], dat(257));
    chk("R9", "offset 2 kept", rbuf[2], dat(2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(4); rst_n = 1'b1; tick(4);
    t_reset(); t_wel(); t_read(); t_abort(); t_pp(); t_gate();
    t_protect(); t_res(); t_err(); t_busy(); t_page();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule